// File: doc/BRIEF.md
# Shifted Accumulate Arithmetic Unit

This block runs the add-to-accumulator instructions of a 16-bit fixed-point signal processor. Each cycle it may receive an instruction word that is already decoded and a 16-bit data operand that is already fetched. In the memory-operand form, the operand is widened to the accumulator width and shifted left by a count held in the instruction. The result is then added into a 32-bit accumulator. In the immediate form, a 13-bit constant from the instruction word is added instead.

Two mode inputs shape the add. The sign-mode input chooses whether the operand is widened with sign extension or with zeros. The saturate-mode input chooses whether a signed overflow wraps or is clamped to the nearest representable extreme. Every executed add produces a carry flag. Overflow sets a sticky flag, and that flag stays set until the surrounding core clears it with a dedicated input.

Top module: `shift_accum_unit`

## Requirements
- R1: While rst_n is low, and in the first cycle after it goes high, acc is 0, ovf_flag is 0 and carry is 0.
- R2: When exec is 1 and instr[15:12] is 4'b0000 (memory form), the next clock edge loads acc with acc + (widened operand << instr[11:8]), so shifts run from 0 to 15.
- R3: In the memory form, sxm=1 widens the operand by copying operand[15] into bits 31:16. With sxm=0, bits 31:16 of the widened operand are zero.
- R4: When exec is 1 and instr[15:13] is 3'b100 (immediate form), the next edge loads acc with acc + {19'b0, instr[12:0]}. Neither operand nor sxm affects this result.
- R5: When exec is 0, or the opcode matches neither form, acc, carry and ovf_flag keep their values. ovf_flag can still be cleared by ovf_clr in that cycle.
- R6: Every executed add sets carry to the carry out of bit 31 of the unsigned 32-bit sum of acc and the addend.
- R7: A signed overflow sets ovf_flag. A signed overflow means acc and the addend have equal bit 31 and the sum's bit 31 differs from it. With ovm=0, acc takes the wrapped 32-bit sum. ovf_flag stays set until cleared.
- R8: When ovm=1 and an executed add overflows, acc becomes 32'h7FFFFFFF if acc was non-negative before the add, and 32'h80000000 if it was negative.
- R9: ovf_clr=1 clears ovf_flag at the next edge unless an overflowing add executes in the same cycle, in which case the flag is set. ovf_clr has no effect on acc or carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec | input | 1 | Execute the instruction presented this cycle |
| instr | input | 16 | Decoded instruction word |
| operand | input | 16 | Fetched data operand |
| sxm | input | 1 | Sign-extend the operand when 1 |
| ovm | input | 1 | Saturate on overflow when 1 |
| ovf_clr | input | 1 | Clear the sticky overflow flag |
| acc | output | 32 | Accumulator |
| ovf_flag | output | 1 | Sticky signed-overflow flag |
| carry | output | 1 | Carry out of the last executed add |

## Verification
The accumulator is also the block's only memory of past adds. A single wrong bit in it therefore shows up in acc one cycle later and carries through every later result. The bench tracks a running model and compares acc after every operation, so a fault is reported on the add that first exposes it. A flag that is wrongly held or wrongly dropped shows up on ovf_flag or carry at the next edge. The sweeps cover every shift count, both extension modes, both overflow modes and the opcode boundary values, so such errors appear within a few cycles of the case that triggers them.

// File: rtl/shift_accum_unit.sv
module shift_accum_unit #(
  parameter int DW = 16,
  parameter int AW = 32,
  parameter int IW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec,
  input  logic [15:0]   instr,
  input  logic [DW-1:0] operand,
  input  logic          sxm,
  input  logic          ovm,
  input  logic          ovf_clr,
  output logic [AW-1:0] acc,
  output logic          ovf_flag,
  output logic          carry
);
  localparam int XW = AW - DW;
  localparam int ZW = AW - IW;
  localparam logic [AW-1:0] POS_MAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] NEG_MIN = {1'b1, {(AW-1){1'b0}}};

  logic          is_mem, is_imm, add_en, ovf;
  logic [AW-1:0] wide_op, addend, next_acc;
  logic [AW:0]   sum;

  assign is_mem  = instr[15:12] == 4'b0000;
  assign is_imm  = instr[15:13] == 3'b100;
  assign add_en  = exec && (is_mem || is_imm);
  assign wide_op = sxm ? {{XW{operand[DW-1]}}, operand} : {{XW{1'b0}}, operand};
  assign addend  = is_mem ? (wide_op << instr[11:8]) : {{ZW{1'b0}}, instr[IW-1:0]};
  assign sum     = {1'b0, acc} + {1'b0, addend};
  assign ovf     = (acc[AW-1] == addend[AW-1]) && (sum[AW-1] != acc[AW-1]);
  assign next_acc = (ovf && ovm) ? (acc[AW-1] ? NEG_MIN : POS_MAX) : sum[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      carry    <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (add_en) begin
        acc   <= next_acc;
        carry <= sum[AW];
      end
      if (add_en && ovf)
        ovf_flag <= 1'b1;
      else if (ovf_clr)
        ovf_flag <= 1'b0;
    end
  end

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !add_en |=> $stable(acc) && $stable(carry));
  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    add_en && ovf |=> ovf_flag);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_clr |=> ovf_flag);
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    add_en && ovf && ovm |=> (acc == POS_MAX || acc == NEG_MIN));
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr && !(add_en && ovf) |=> !ovf_flag);
  a_r1_reset: assert property (@(posedge clk)
    !rst_n |=> acc == '0 && !ovf_flag && !carry);
endmodule

// File: tb/sim_shift_accum_unit.sv
module sim_shift_accum_unit;
  logic clk = 1'b0, rst_n = 1'b0, exec = 1'b0, sxm = 1'b0, ovm = 1'b0, ovf_clr = 1'b0;
  logic [15:0] instr = '0, operand = '0;
  logic [31:0] acc;
  logic ovf_flag, carry;
  int total = 0, bad = 0;
  logic [31:0] m_acc = '0;
  logic m_ov = 1'b0, m_c = 1'b0;

  always #2 clk = ~clk;

  shift_accum_unit u0 (.clk(clk), .rst_n(rst_n), .exec(exec), .instr(instr),
    .operand(operand), .sxm(sxm), .ovm(ovm), .ovf_clr(ovf_clr),
    .acc(acc), .ovf_flag(ovf_flag), .carry(carry));

  task automatic check(input string tag);
    total++;
    if (acc !== m_acc || ovf_flag !== m_ov || carry !== m_c) begin
      bad++;
      $display("FAIL %s: acc=%h ov=%b c=%b expected acc=%h ov=%b c=%b",
               tag, acc, ovf_flag, carry, m_acc, m_ov, m_c);
    end
  endtask

  task automatic op(input logic [15:0] ins, input logic [15:0] d, input logic s,
                    input logic o, input logic clr, input logic en, input string tag);
    logic [31:0] add;
    logic [32:0] s33;
    logic go, ovf;
    @(negedge clk);
    instr = ins; operand = d; sxm = s; ovm = o; ovf_clr = clr; exec = en;
    go = en && (ins[15:12] == 4'b0000 || ins[15:13] == 3'b100);
    if (ins[15:12] == 4'b0000)
      add = (s ? {{16{d[15]}}, d} : {16'h0, d}) << ins[11:8];
    else
      add = {19'h0, ins[12:0]};
    s33 = {1'b0, m_acc} + {1'b0, add};
    ovf = (m_acc[31] == add[31]) && (s33[31] != m_acc[31]);
    if (go && ovf) m_ov = 1'b1;
    else if (clr) m_ov = 1'b0;
    if (go) begin
      m_c = s33[32];
      m_acc = (ovf && o) ? (m_acc[31] ? 32'h8000_0000 : 32'h7FFF_FFFF) : s33[31:0];
    end
    @(posedge clk); #1;
    check(tag);
    exec = 1'b0; ovf_clr = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    m_acc = '0; m_ov = 1'b0; m_c = 1'b0;
    #1 check("R1");
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] pats [6];
    pats[0] = 16'h0001; pats[1] = 16'h7FFF; pats[2] = 16'h8000;
    pats[3] = 16'hFFFF; pats[4] = 16'h1234; pats[5] = 16'h0008;
    do_reset();
    // R2 example: 2 then 8<<3 gives 0x42
    op(16'h8002, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, "R4");
    op(16'h0300, 16'h0008, 1'b1, 1'b0, 1'b0, 1'b1, "R2");
    total++;
    if (acc !== 32'h42) begin
      bad++; $display("FAIL R2: acc=%h expected 00000042", acc);
    end
    // R2 R3 R6 R7 R8 R9 sweep
    for (int o = 0; o < 2; o++)
      for (int s = 0; s < 2; s++)
        for (int sh = 0; sh < 16; sh++)
          for (int p = 0; p < 6; p++)
            op({4'h0, sh[3:0], 8'h5A}, pats[p], s[0], o[0], (p == 2), 1'b1,
               o ? "R8" : (s ? "R3" : "R2"));
    do_reset();
    // R6 carry without overflow: -1 + 1
    op(16'h0000, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1, "R3");
    op(16'h0000, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
    total++;
    if (carry !== 1'b1 || acc !== 32'h0) begin
      bad++; $display("FAIL R6: acc=%h c=%b expected 00000000 1", acc, carry);
    end
    // R4 immediate sweep, operand and sxm ignored
    for (int k = 0; k < 64; k++)
      op({3'b100, k[5:0], 7'h7F}, 16'hFFFF, k[0], 1'b0, 1'b0, 1'b1, "R4");
    op(16'h9FFF, 16'h0, 1'b1, 1'b1, 1'b0, 1'b1, "R4");
    // R5 ignored opcodes and idle exec
    for (int k = 1; k < 16; k++)
      if (k[3:1] != 3'b100)
        op({k[3:0], 12'hF00}, 16'h7FFF, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
    op(16'h0F00, 16'h7FFF, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    // R7 R9 overflow then clear, clear colliding with overflow
    op(16'h0F00, 16'h7FFF, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    op(16'h0F00, 16'h7FFF, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    op(16'h0F00, 16'h7FFF, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    op(16'h0F00, 16'h7FFF, 1'b0, 1'b1, 1'b1, 1'b1, "R9");
    op(16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
    op(16'h0F00, 16'h7FFF, 1'b0, 1'b1, 1'b1, 1'b1, "R8");
    op(16'h0F00, 16'h8000, 1'b1, 1'b1, 1'b0, 1'b1, "R8");
    op(16'h0F00, 16'h8000, 1'b1, 1'b1, 1'b0, 1'b1, "R8");
    op(16'h0F00, 16'h8000, 1'b1, 1'b1, 1'b0, 1'b1, "R8");
    op(16'h0F00, 16'h8000, 1'b1, 1'b1, 1'b0, 1'b1, "R8");
    do_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule